// File: doc/BRIEF.md
# Rotating-Thread Pipeline Core

This block is a small processor core that carries several hardware threads at once and gives each one a fixed turn. On every clock a different thread fetches. The threads are served in a fixed cycle 0, 1, 2, 3, 0, … and the pipeline has one stage per thread: fetch, decode with register read, execute, and writeback. Because of this, any two stages always hold different threads. A thread's writeback lands in the cycle just before its next fetch. The core therefore has no stall, interlock or forwarding paths, and switching between threads costs nothing.

Each thread owns an 8-bit program counter, four 8-bit registers and a halt flag, all kept in on-chip flops. Instructions come from an internal 256-word instruction store. It is filled through a write port, normally while reset is held. Thread i starts at word 16·i. A debug port reads any register of any thread, and a status vector shows which threads have halted. When a thread halts, it keeps its slot in the cycle and leaves it empty, so the timing of the other threads never moves.

Instruction word (16 bits): opcode in bits 15:12, destination register select in 11:10, source register select in 9:8, and an 8-bit immediate or branch target in 7:0.

Top module: `rr_thread_core`

## Requirements
- R1: `fetch_tid` is 0 in the first cycle with `rst` low and then advances by one every clock, wrapping from 3 to 0, so no thread holds two slots in a row.
- R2: A clock with `rst` high clears every thread register to 0, clears `halted`, sets `fetch_tid` to 0 and loads thread i's program counter with 16·i.
- R3: Opcode 0x1 (load immediate) writes bits 7:0 into the destination register.
- R4: Opcode 0x2 adds and opcode 0x3 subtracts the source register into the destination register (dest ← dest ± src), modulo 256.
- R5: Opcode 0x4 (branch if zero) sets the thread's next address to bits 7:0 when the source register is 0, and to the following word otherwise. There is no delay slot.
- R6: An instruction sees the register results of the same thread's previous instruction, with no extra cycles.
- R7: Opcode 0xF (halt) sets the thread's `halted` bit, which stays set until reset. Instructions after it are never executed.
- R8: If a thread executes n instructions before its halt instruction, `halted[i]` first reads 1 in cycle 4·n+i+4, counting cycle 0 as in R1. This holds whatever the other threads do, including endless loops. At most one bit of `halted` rises per cycle.
- R9: Every other opcode value (0x0, 0x5 to 0xE) changes no register and advances to the next word.
- R10: `dbg_data` shows register `dbg_sel` of thread `dbg_tid` one clock after the select is applied.
- R11: While `imem_we` is high, each clock writes `imem_wdata` to word `imem_waddr` of the instruction store. This also works while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 8 | Instruction store write address |
| imem_wdata | input | 16 | Instruction word to write |
| dbg_tid | input | 2 | Thread selected for debug read |
| dbg_sel | input | 2 | Register selected for debug read |
| dbg_data | output | 8 | Registered debug read value |
| fetch_tid | output | 2 | Thread holding the fetch slot this cycle |
| halted | output | 4 | Per-thread halt flags |

## Verification
The assertions assume two things about the inputs. First, reset is held for at least two clocks. Second, the instruction store is written only while reset is high, so the rotation and halt-flag properties are judged only on a program that cannot change while it runs. The bench loads every word of the store with reset asserted and releases reset only after the last write. Its random programs keep each thread inside its own 16-word window. Branch targets only point forward, and the window ends in a halt, so every random thread halts within 16 issues. The directed cases add the backward branches: an endless self-loop and a counted loop.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  // Instruction word geometry
  localparam int OPW   = 4;
  localparam int RSELW = 2;
  localparam int IMMW  = 8;
  localparam int INSTW = OPW + 2 * RSELW + IMMW;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_BEZ  = 4'h4,
    OP_HALT = 4'hF
  } op_e;

  typedef struct packed {
    logic [OPW-1:0]   op;
    logic [RSELW-1:0] rd;
    logic [RSELW-1:0] rs;
    logic [IMMW-1:0]  imm;
  } instr_t;
endpackage

// File: rtl/rrt_imem.sv
// Simple dual-port instruction store: one write port, one registered read.
module rrt_imem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rrt_regbank.sv
// Per-thread register banks: two combinational read ports for decode,
// one write port for writeback, one registered debug read port.
module rrt_regbank #(
  parameter int THREADS = 4,
  parameter int NREG    = 4,
  parameter int DW      = 8,
  localparam int TW     = $clog2(THREADS),
  localparam int SW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] rd_tid,
  input  logic [SW-1:0] ra_sel,
  input  logic [SW-1:0] rb_sel,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [TW-1:0] w_tid,
  input  logic [SW-1:0] w_sel,
  input  logic [DW-1:0] w_data,
  input  logic [TW-1:0] dbg_tid,
  input  logic [SW-1:0] dbg_sel,
  output logic [DW-1:0] dbg_data
);
  logic [DW-1:0] bank [THREADS][NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < THREADS; t++)
        for (int r = 0; r < NREG; r++)
          bank[t][r] <= '0;
    end else if (we) begin
      bank[w_tid][w_sel] <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= bank[dbg_tid][dbg_sel];
  end

  assign ra_data = bank[rd_tid][ra_sel];
  assign rb_data = bank[rd_tid][rb_sel];
endmodule

// File: rtl/rrt_ctxbank.sv
// Per-thread program counters and halt flags.
module rrt_ctxbank #(
  parameter int THREADS = 4,
  parameter int PCW     = 8,
  parameter int STRIDE  = 16,
  localparam int TW     = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TW-1:0]      f_tid,
  output logic [PCW-1:0]     f_pc,
  output logic               f_halted,
  input  logic               w_en,
  input  logic [TW-1:0]      w_tid,
  input  logic [PCW-1:0]     w_pc,
  input  logic               w_halt,
  output logic [THREADS-1:0] halted
);
  logic [PCW-1:0]     pc_q [THREADS];
  logic [THREADS-1:0] halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < THREADS; i++) pc_q[i] <= PCW'(i * STRIDE);
      halt_q <= '0;
    end else if (w_en) begin
      pc_q[w_tid] <= w_pc;
      if (w_halt) halt_q[w_tid] <= 1'b1;
    end
  end

  assign f_pc     = pc_q[f_tid];
  assign f_halted = halt_q[f_tid];
  assign halted   = halt_q;
endmodule

// File: rtl/rrt_exec.sv
// Execute stage: result, register write enable, next address, halt.
module rrt_exec
  import rrt_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PCW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  imm,
  input  logic [PCW-1:0] pc,
  output logic           wr,
  output logic [DW-1:0]  res,
  output logic [PCW-1:0] npc,
  output logic           halt
);
  op_e opc;
  assign opc = op_e'(op);

  always_comb begin
    wr   = 1'b0;
    res  = a;
    npc  = pc + 1'b1;
    halt = 1'b0;
    case (opc)
      OP_LDI: begin wr = 1'b1; res = imm;   end
      OP_ADD: begin wr = 1'b1; res = a + b; end
      OP_SUB: begin wr = 1'b1; res = a - b; end
      OP_BEZ: if (b == '0) npc = PCW'(imm);
      OP_HALT: begin halt = 1'b1; npc = pc; end
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_thread_core.sv
// Interleaved multithreaded core: one issue per clock, thread slots in a
// fixed cycle, pipeline depth equal to the thread count.
module rr_thread_core
  import rrt_pkg::*;
#(
  parameter int THREADS      = 4,
  parameter int START_STRIDE = 16,
  localparam int TW          = $clog2(THREADS),
  localparam int NREG        = 1 << RSELW,
  localparam int DW          = IMMW,
  localparam int PCW         = IMMW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_we,
  input  logic [PCW-1:0]     imem_waddr,
  input  logic [INSTW-1:0]   imem_wdata,
  input  logic [TW-1:0]      dbg_tid,
  input  logic [RSELW-1:0]   dbg_sel,
  output logic [DW-1:0]      dbg_data,
  output logic [TW-1:0]      fetch_tid,
  output logic [THREADS-1:0] halted
);
  // Stages: fetch, decode, execute, PAD delay slots, writeback
  localparam int PAD = THREADS - 4;

  if (THREADS < 4) begin : g_bad_threads
    $error("rr_thread_core needs at least four threads");
  end

  typedef struct packed {
    logic             v;
    logic [TW-1:0]    tid;
    logic             wr;
    logic [RSELW-1:0] rd;
    logic [DW-1:0]    res;
    logic [PCW-1:0]   npc;
    logic             halt;
  } wb_t;

  // ---------------- fetch slot rotation ----------------
  always_ff @(posedge clk) begin
    if (rst)                               fetch_tid <= '0;
    else if (fetch_tid == TW'(THREADS-1))  fetch_tid <= '0;
    else                                   fetch_tid <= fetch_tid + 1'b1;
  end

  logic [PCW-1:0]   f_pc;
  logic             f_halted;
  logic [INSTW-1:0] imem_rdata;
  wb_t              wb;

  rrt_ctxbank #(.THREADS(THREADS), .PCW(PCW), .STRIDE(START_STRIDE)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .f_tid    (fetch_tid),
    .f_pc     (f_pc),
    .f_halted (f_halted),
    .w_en     (wb.v),
    .w_tid    (wb.tid),
    .w_pc     (wb.npc),
    .w_halt   (wb.halt),
    .halted   (halted)
  );

  rrt_imem #(.AW(PCW), .DW(INSTW)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (imem_waddr),
    .wdata (imem_wdata),
    .raddr (f_pc),
    .rdata (imem_rdata)
  );

  // ---------------- decode stage ----------------
  logic           v1;
  logic [TW-1:0]  tid1;
  logic [PCW-1:0] pc1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      tid1 <= '0;
      pc1  <= '0;
    end else begin
      v1   <= !f_halted;       // halted thread keeps its slot as a bubble
      tid1 <= fetch_tid;
      pc1  <= f_pc;
    end
  end

  instr_t        ins1;
  logic [DW-1:0] ra1, rb1;
  assign ins1 = instr_t'(imem_rdata);

  rrt_regbank #(.THREADS(THREADS), .NREG(NREG), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_tid   (tid1),
    .ra_sel   (ins1.rd),
    .rb_sel   (ins1.rs),
    .ra_data  (ra1),
    .rb_data  (rb1),
    .we       (wb.v && wb.wr),
    .w_tid    (wb.tid),
    .w_sel    (wb.rd),
    .w_data   (wb.res),
    .dbg_tid  (dbg_tid),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
  );

  // ---------------- execute stage ----------------
  logic             v2;
  logic [TW-1:0]    tid2;
  logic [PCW-1:0]   pc2;
  logic [OPW-1:0]   op2;
  logic [RSELW-1:0] rd2;
  logic [DW-1:0]    imm2, a2, b2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2   <= 1'b0;
      tid2 <= '0;
      pc2  <= '0;
      op2  <= '0;
      rd2  <= '0;
      imm2 <= '0;
      a2   <= '0;
      b2   <= '0;
    end else begin
      v2   <= v1;
      tid2 <= tid1;
      pc2  <= pc1;
      op2  <= ins1.op;
      rd2  <= ins1.rd;
      imm2 <= ins1.imm;
      a2   <= ra1;
      b2   <= rb1;
    end
  end

  logic           x_wr, x_halt;
  logic [DW-1:0]  x_res;
  logic [PCW-1:0] x_npc;

  rrt_exec #(.DW(DW), .PCW(PCW)) u_exec (
    .op   (op2),
    .a    (a2),
    .b    (b2),
    .imm  (imm2),
    .pc   (pc2),
    .wr   (x_wr),
    .res  (x_res),
    .npc  (x_npc),
    .halt (x_halt)
  );

  wb_t x_out;
  always_comb begin
    x_out.v    = v2;
    x_out.tid  = tid2;
    x_out.wr   = x_wr;
    x_out.rd   = rd2;
    x_out.res  = x_res;
    x_out.npc  = x_npc;
    x_out.halt = x_halt;
  end

  // ---------------- writeback chain (padded when THREADS > 4) ----------------
  wb_t wb_q [PAD+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= PAD; k++) wb_q[k] <= '0;
    end else begin
      wb_q[0] <= x_out;
      for (int k = 1; k <= PAD; k++) wb_q[k] <= wb_q[k-1];
    end
  end

  assign wb = wb_q[PAD];
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int THREADS = 4,
  localparam int TW     = $clog2(THREADS)
) (
  input logic               clk,
  input logic               rst,
  input logic [TW-1:0]      fetch_tid,
  input logic [THREADS-1:0] halted
);
  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fetch_tid == (($past(fetch_tid) == TW'(THREADS-1)) ? '0 : $past(fetch_tid) + 1'b1)); // R1

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (fetch_tid == '0 && halted == '0)); // R2

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (halted & $past(halted)) == $past(halted)); // R7

  AST_HALT_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(halted)) |-> $countones(halted ^ $past(halted)) == 1); // R8

  for (genvar i = 0; i < THREADS; i++) begin : g_slot
    AST_HALT_IN_OWN_SLOT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(halted[i])) |-> fetch_tid == TW'(i)); // R8
  end
endmodule

bind rr_thread_core rrt_checker #(.THREADS(THREADS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fetch_tid (fetch_tid),
  .halted    (halted)
);

// File: tb/sim_rr_thread_core.sv
`timescale 1ns/1ps
module sim_rr_thread_core;
  localparam int NT      = 4;
  localparam int NR      = 4;
  localparam int MAXSTEP = 64;
  localparam int RUN_CYC = 4 * MAXSTEP + 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [7:0]  imem_waddr = '0;
  logic [15:0] imem_wdata = '0;
  logic [1:0]  dbg_tid = '0;
  logic [1:0]  dbg_sel = '0;
  logic [7:0]  dbg_data;
  logic [1:0]  fetch_tid;
  logic [3:0]  halted;

  always #4 clk = ~clk;   // 125 MHz

  rr_thread_core u0 (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_tid(dbg_tid), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .fetch_tid(fetch_tid), .halted(halted)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  logic [15:0] rom_img [256];
  int          exp_n [NT];
  logic [7:0]  exp_r [NT][NR];
  int          seen_at [NT];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] op, input logic [1:0] rd,
                                     input logic [1:0] rs, input logic [7:0] im);
    return {op, rd, rs, im};
  endfunction

  task automatic clear_rom();
    for (int a = 0; a < 256; a++) rom_img[a] = 16'h0000;
  endtask

  // Architectural reference: one thread at a time, in program order.
  task automatic model_all();
    for (int t = 0; t < NT; t++) begin
      logic [7:0]  pc;
      logic [7:0]  r [NR];
      logic [15:0] w;
      pc = 8'(16 * t);
      for (int k = 0; k < NR; k++) r[k] = 8'h00;
      exp_n[t] = -1;
      for (int s = 0; s < MAXSTEP; s++) begin
        w = rom_img[pc];
        if (w[15:12] == 4'hF) begin
          exp_n[t] = s;
          break;
        end
        case (w[15:12])
          4'h1: begin r[w[11:10]] = w[7:0]; pc = pc + 8'd1; end
          4'h2: begin r[w[11:10]] = r[w[11:10]] + r[w[9:8]]; pc = pc + 8'd1; end
          4'h3: begin r[w[11:10]] = r[w[11:10]] - r[w[9:8]]; pc = pc + 8'd1; end
          4'h4: pc = (r[w[9:8]] == 8'h00) ? w[7:0] : pc + 8'd1;
          default: pc = pc + 8'd1;
        endcase
      end
      for (int k = 0; k < NR; k++) exp_r[t][k] = r[k];
    end
  endtask

  // Random program confined to the thread's window, forward branches only.
  task automatic gen_thread(input int t);
    int base;
    base = 16 * t;
    for (int a = 0; a < 15; a++) begin
      int         kind;
      logic [1:0] rd, rs;
      logic [7:0] im;
      kind = int'($urandom % 8);
      rd = 2'($urandom);
      rs = 2'($urandom);
      im = 8'($urandom);
      case (kind)
        0, 1: rom_img[base+a] = mk(4'h1, rd, rs, im);
        2:    rom_img[base+a] = mk(4'h2, rd, rs, im);
        3:    rom_img[base+a] = mk(4'h3, rd, rs, im);
        4, 5: rom_img[base+a] = mk(4'h4, rd, rs, 8'(base + a + 1 + int'($urandom % (15 - a))));
        6:    rom_img[base+a] = mk(4'h5 + 4'($urandom % 10), rd, rs, im);
        default: rom_img[base+a] = ($urandom % 4 == 0) ? mk(4'hF, rd, rs, im)
                                                       : mk(4'h1, rd, rs, im);
      endcase
    end
    rom_img[base+15] = mk(4'hF, 2'd0, 2'd0, 8'h00);
  endtask

  task automatic run_case(input string name, input bit chk_reset);
    bit         rot_ok;
    int         bad_act, bad_exp;
    logic [3:0] exp_mask;
    rst = 1'b1;
    @(negedge clk);
    // R11: store written while reset is held
    for (int a = 0; a < 256; a++) begin
      imem_we    = 1'b1;
      imem_waddr = 8'(a);
      imem_wdata = rom_img[a];
      @(negedge clk);
    end
    imem_we = 1'b0;
    if (chk_reset) begin
      #1;
      check(fetch_tid == 2'd0, "R2", {name, " fetch_tid in reset"}, int'(fetch_tid), 0);
      check(halted == 4'd0, "R2", {name, " halted in reset"}, int'(halted), 0);
      for (int t = 0; t < NT; t++)
        for (int r = 0; r < NR; r++) begin
          dbg_tid = 2'(t);
          dbg_sel = 2'(r);
          @(negedge clk);
          #1;
          check(dbg_data == 8'h00, "R2", {name, " register cleared by reset"}, int'(dbg_data), 0);
        end
    end
    model_all();
    for (int t = 0; t < NT; t++) seen_at[t] = -1;
    rot_ok = 1'b1;
    bad_act = 0;
    bad_exp = 0;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < RUN_CYC; k++) begin
      #1;
      if (rot_ok && fetch_tid != 2'(k % NT)) begin
        rot_ok  = 1'b0;
        bad_act = int'(fetch_tid);
        bad_exp = k % NT;
      end
      for (int t = 0; t < NT; t++)
        if (halted[t] && seen_at[t] < 0) seen_at[t] = k;
      @(negedge clk);
    end
    check(rot_ok, "R1", {name, " fetch slot rotation"}, bad_act, bad_exp);
    exp_mask = '0;
    for (int t = 0; t < NT; t++) begin
      int e;
      e = (exp_n[t] < 0) ? -1 : 4 * exp_n[t] + t + 4;
      exp_mask[t] = (exp_n[t] >= 0);
      check(seen_at[t] == e, "R8", {name, " halt flag cycle"}, seen_at[t], e);
    end
    #1;
    check(halted == exp_mask, "R7", {name, " final halt flags"}, int'(halted), int'(exp_mask));
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < NR; r++) begin
        @(negedge clk);
        dbg_tid = 2'(t);
        dbg_sel = 2'(r);
        @(negedge clk);
        #1;
        check(dbg_data == exp_r[t][r], "R3 R4 R5 R6 R9 R10 R11",
              $sformatf("%s thread %0d reg %0d", name, t, r),
              int'(dbg_data), int'(exp_r[t][r]));
      end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7301));

    // Directed A: start addresses (R2), chains (R6), wrap (R4),
    // branch taken/not taken (R5), unknown opcode (R9), halt stop (R7).
    clear_rom();
    rom_img[0]  = mk(4'h1, 2'd0, 2'd0, 8'hA0);
    rom_img[1]  = mk(4'h1, 2'd1, 2'd0, 8'h05);
    rom_img[2]  = mk(4'h2, 2'd1, 2'd1, 8'h00);
    rom_img[3]  = mk(4'h2, 2'd1, 2'd1, 8'h00);
    rom_img[4]  = mk(4'h3, 2'd1, 2'd0, 8'h00);
    rom_img[5]  = mk(4'h2, 2'd2, 2'd1, 8'h00);
    rom_img[6]  = mk(4'hF, 2'd0, 2'd0, 8'h00);
    rom_img[16] = mk(4'h1, 2'd0, 2'd0, 8'h11);
    rom_img[17] = mk(4'h7, 2'd0, 2'd0, 8'h55);
    rom_img[18] = mk(4'h0, 2'd0, 2'd0, 8'h66);
    rom_img[19] = mk(4'hF, 2'd0, 2'd0, 8'h00);
    rom_img[32] = mk(4'h1, 2'd3, 2'd0, 8'hFF);
    rom_img[33] = mk(4'h1, 2'd1, 2'd0, 8'h01);
    rom_img[34] = mk(4'h2, 2'd3, 2'd1, 8'h00);
    rom_img[35] = mk(4'h4, 2'd0, 2'd3, 8'd40);
    rom_img[36] = mk(4'h1, 2'd0, 2'd0, 8'hEE);
    rom_img[40] = mk(4'h4, 2'd0, 2'd1, 8'd50);
    rom_img[41] = mk(4'h1, 2'd0, 2'd0, 8'h42);
    rom_img[42] = mk(4'hF, 2'd0, 2'd0, 8'h00);
    rom_img[48] = mk(4'h1, 2'd2, 2'd0, 8'h33);
    rom_img[49] = mk(4'hF, 2'd0, 2'd0, 8'h00);
    rom_img[50] = mk(4'h1, 2'd2, 2'd0, 8'h99);
    run_case("directed-a", 1'b0);

    // Directed B: thread 2 spins forever, thread 0 runs a counted loop (R8).
    clear_rom();
    rom_img[0]  = mk(4'h1, 2'd0, 2'd0, 8'd3);
    rom_img[1]  = mk(4'h1, 2'd1, 2'd0, 8'd1);
    rom_img[2]  = mk(4'h3, 2'd0, 2'd1, 8'h00);
    rom_img[3]  = mk(4'h4, 2'd0, 2'd0, 8'd5);
    rom_img[4]  = mk(4'h4, 2'd0, 2'd2, 8'd2);
    rom_img[5]  = mk(4'h1, 2'd3, 2'd0, 8'h5A);
    rom_img[6]  = mk(4'hF, 2'd0, 2'd0, 8'h00);
    rom_img[32] = mk(4'h4, 2'd0, 2'd0, 8'd32);
    gen_thread(1);
    gen_thread(3);
    run_case("spin-loop", 1'b1);

    for (int c = 0; c < 8; c++) begin
      clear_rom();
      for (int t = 0; t < NT; t++) gen_thread(t);
      run_case($sformatf("random-%0d", c), 1'b1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule